// File: doc/BRIEF.md
# Rate-Limit Frame Byte Charger

This block sits beside a port's rate limiter and turns each finished frame into a byte charge. On an end-of-frame strobe it looks at the frame's class flags (broadcast, multicast, unicast flooded after a lookup miss) and at a 2-bit limit mode. From these it decides whether the frame is subject to limiting. A frame that qualifies is charged its length plus two optional fixed overheads: the minimum inter-frame gap and the preamble. A frame that does not qualify is charged nothing.

The charge and a qualify pulse come out one cycle after the strobe. The block also adds the charge into a saturating running total, which a token-bucket or window limiter can sample. A clear input zeroes that total. The same overhead enables are meant to be shared by the ingress and egress instances of the block. All configuration inputs are expected to reset to zero, which selects "every frame, no overhead".

Top module: `rl_frame_charge`

## Requirements
- R1: After reset, `qual_o` is 0, `charge_o` is 0 and `acc_o` is 0.
- R2: With `lim_mode_i` = 0, every frame qualifies, whatever its class flags.
- R3: With `lim_mode_i` = 1, a frame qualifies only if it is broadcast, multicast or flooded unicast.
- R4: With `lim_mode_i` = 2, a frame qualifies only if it is broadcast or multicast.
- R5: With `lim_mode_i` = 3, a frame qualifies only if it is broadcast.
- R6: A frame with both `is_bcast_i` and `is_mcast_i` set is classed as broadcast, so it qualifies in every mode, including mode 3.
- R7: One cycle after `eof_i`, a qualifying frame gives `qual_o` = 1 and `charge_o` = `frame_len_i` + 12·`add_gap_i` + 8·`add_pre_i`.
- R8: A non-qualifying frame gives `qual_o` = 0 and `charge_o` = 0 in the cycle after its strobe, and leaves `acc_o` unchanged.
- R9: In any cycle after a cycle with `eof_i` low, `qual_o` and `charge_o` are both 0.
- R10: In the cycle after `qual_o` is 1, `acc_o` grows by `charge_o`, clamped at 2^32−1. Otherwise `acc_o` holds.
- R11: `acc_clr_i` high sets `acc_o` to 0 on the next cycle. The clear wins over a charge that would be added in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eof_i | input | 1 | End-of-frame strobe, one cycle per frame |
| frame_len_i | input | 16 | Frame length in bytes, valid with `eof_i` |
| is_bcast_i | input | 1 | Frame is broadcast |
| is_mcast_i | input | 1 | Frame is multicast |
| is_flood_i | input | 1 | Frame is unicast flooded after a lookup miss |
| lim_mode_i | input | 2 | Limit mode: 0 all, 1 bcast/mcast/flood, 2 bcast/mcast, 3 bcast |
| add_gap_i | input | 1 | Add 12 inter-frame gap bytes to each charge |
| add_pre_i | input | 1 | Add 8 preamble bytes to each charge |
| acc_clr_i | input | 1 | Zero the running total |
| qual_o | output | 1 | Frame of the previous cycle qualified |
| charge_o | output | 17 | Byte charge of the previous cycle's frame |
| acc_o | output | 32 | Saturating running byte total |

## Verification
Every mode is driven with all eight combinations of the three class flags. This separates the four qualify sets from one another, and it also catches a broadcast-plus-multicast frame that is wrongly dropped in mode 3. The four overhead enable pairs are applied to the same lengths, so a swapped or missing 12 or 8 shows up as a charge error. A long random run mixes strobe gaps, back-to-back frames and occasional clears, which tests that the total holds when no frame qualifies. Two directed runs finish the set: a clear placed on the same edge as a pending charge, and a stream of maximum-length frames that drives the total into its clamp.

// File: rtl/rl_pkg.sv
package rl_pkg;
  typedef enum logic [1:0] {
    LM_ALL     = 2'd0,
    LM_BC_MC_F = 2'd1,
    LM_BC_MC   = 2'd2,
    LM_BC      = 2'd3
  } lim_mode_e;

  localparam int unsigned GAP_BYTES = 12;
  localparam int unsigned PRE_BYTES = 8;
  localparam int unsigned OVH_MAX   = GAP_BYTES + PRE_BYTES;
endpackage

// File: rtl/rl_rst_sync.sv
module rl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rl_class_filter.sv
module rl_class_filter
  import rl_pkg::*;
(
  input  lim_mode_e mode_i,
  input  logic      bcast_i,
  input  logic      mcast_i,
  input  logic      flood_i,
  output logic      qualify_o
);
  logic is_b, is_m, is_f;

  // Broadcast dominates so that a frame carrying both flags is one class only.
  always_comb begin
    is_b = bcast_i;
    is_m = mcast_i & ~bcast_i;
    is_f = flood_i & ~bcast_i & ~mcast_i;
    unique case (mode_i)
      LM_ALL:     qualify_o = 1'b1;
      LM_BC_MC_F: qualify_o = is_b | is_m | is_f;
      LM_BC_MC:   qualify_o = is_b | is_m;
      LM_BC:      qualify_o = is_b;
      default:    qualify_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rl_overhead_add.sv
module rl_overhead_add
  import rl_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  localparam int unsigned CHG_W = LEN_W + 1
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             gap_en_i,
  input  logic             pre_en_i,
  output logic [CHG_W-1:0] charge_o
);
  localparam logic [CHG_W-1:0] GAP_C = CHG_W'(GAP_BYTES);
  localparam logic [CHG_W-1:0] PRE_C = CHG_W'(PRE_BYTES);

  always_comb begin
    charge_o = CHG_W'(len_i)
             + (gap_en_i ? GAP_C : '0)
             + (pre_en_i ? PRE_C : '0);
  end
endmodule

// File: rtl/rl_sat_accum.sv
module rl_sat_accum #(
  parameter int unsigned IN_W  = 17,
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             add_en_i,
  input  logic [IN_W-1:0]  add_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic             acc_en;

  always_comb begin
    sum    = {1'b0, acc_q} + (ACC_W+1)'(add_i);
    acc_en = clr_i | add_en_i;
    if (clr_i)       acc_d = '0;
    else if (sum[ACC_W]) acc_d = ACC_MAX;
    else             acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/rl_frame_charge.sv
module rl_frame_charge
  import rl_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned ACC_W = 32,
  localparam int unsigned CHG_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic             is_bcast_i,
  input  logic             is_mcast_i,
  input  logic             is_flood_i,
  input  logic [1:0]       lim_mode_i,
  input  logic             add_gap_i,
  input  logic             add_pre_i,
  input  logic             acc_clr_i,
  output logic             qual_o,
  output logic [CHG_W-1:0] charge_o,
  output logic [ACC_W-1:0] acc_o
);
  logic             rst_sync_n;
  logic             hit;
  logic [CHG_W-1:0] raw_charge;
  logic             qual_q, qual_d;
  logic [CHG_W-1:0] chg_q, chg_d;
  logic             out_en;

  rl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rl_class_filter u_filt (
    .mode_i    (lim_mode_e'(lim_mode_i)),
    .bcast_i   (is_bcast_i),
    .mcast_i   (is_mcast_i),
    .flood_i   (is_flood_i),
    .qualify_o (hit)
  );

  rl_overhead_add #(.LEN_W(LEN_W)) u_ovh (
    .len_i    (frame_len_i),
    .gap_en_i (add_gap_i),
    .pre_en_i (add_pre_i),
    .charge_o (raw_charge)
  );

  // The output stage loads on a strobe and also when it must drop back to zero.
  always_comb begin
    qual_d = eof_i & hit;
    chg_d  = qual_d ? raw_charge : '0;
    out_en = eof_i | qual_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      qual_q <= 1'b0;
      chg_q  <= '0;
    end else if (out_en) begin
      qual_q <= qual_d;
      chg_q  <= chg_d;
    end
  end

  rl_sat_accum #(.IN_W(CHG_W), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (acc_clr_i),
    .add_en_i (qual_q),
    .add_i    (chg_q),
    .acc_o    (acc_o)
  );

  assign qual_o   = qual_q;
  assign charge_o = chg_q;
endmodule

// File: rtl/rl_frame_charge_chk.sv
module rl_frame_charge_chk #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned ACC_W = 32,
  localparam int unsigned CHG_W = LEN_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eof_i,
  input logic             is_bcast_i,
  input logic [1:0]       lim_mode_i,
  input logic             acc_clr_i,
  input logic             qual_o,
  input logic [CHG_W-1:0] charge_o,
  input logic [ACC_W-1:0] acc_o
);
  a_r2_all_frames: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_i && lim_mode_i == 2'd0) |=> qual_o);

  a_r5_bcast_only: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_i && lim_mode_i == 2'd3 && !is_bcast_i) |=> !qual_o);

  a_r6_bcast_always: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_i && is_bcast_i) |=> qual_o);

  a_r8_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_o |-> charge_o == '0);

  a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !eof_i |=> !qual_o);

  a_r10_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_clr_i |=> acc_o >= $past(acc_o));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr_i && !qual_o) |=> $stable(acc_o));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr_i |=> acc_o == '0);
endmodule

bind rl_frame_charge rl_frame_charge_chk #(.LEN_W(LEN_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .eof_i      (eof_i),
  .is_bcast_i (is_bcast_i),
  .lim_mode_i (lim_mode_i),
  .acc_clr_i  (acc_clr_i),
  .qual_o     (qual_o),
  .charge_o   (charge_o),
  .acc_o      (acc_o)
);

// File: tb/tb_rl_frame_charge.sv
module tb_rl_frame_charge;
  logic        clk;
  logic        rst_n;
  logic        eof_i;
  logic [15:0] frame_len_i;
  logic        is_bcast_i, is_mcast_i, is_flood_i;
  logic [1:0]  lim_mode_i;
  logic        add_gap_i, add_pre_i, acc_clr_i;
  logic        qual_o;
  logic [16:0] charge_o;
  logic [31:0] acc_o;

  int total = 0;
  int bad   = 0;

  logic        e_qual;
  logic [16:0] e_chg;
  logic [31:0] e_acc;
  logic        last_clr;

  rl_frame_charge dut (
    .clk(clk), .rst_n(rst_n), .eof_i(eof_i), .frame_len_i(frame_len_i),
    .is_bcast_i(is_bcast_i), .is_mcast_i(is_mcast_i), .is_flood_i(is_flood_i),
    .lim_mode_i(lim_mode_i), .add_gap_i(add_gap_i), .add_pre_i(add_pre_i),
    .acc_clr_i(acc_clr_i), .qual_o(qual_o), .charge_o(charge_o), .acc_o(acc_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic qualifies(logic [1:0] m, logic b, logic mc, logic f);
    case (m)
      2'd0:    return 1'b1;
      2'd1:    return b | mc | f;
      2'd2:    return b | mc;
      default: return b;
    endcase
  endfunction

  function automatic logic [16:0] cost(logic [15:0] len, logic g, logic p);
    return 17'(len) + (g ? 17'd12 : 17'd0) + (p ? 17'd8 : 17'd0);
  endfunction

  function automatic logic [31:0] sat_add(logic [31:0] a, logic [16:0] b);
    logic [32:0] s;
    s = {1'b0, a} + 33'(b);
    return s[32] ? 32'hFFFF_FFFF : s[31:0];
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, model the rising edge, compare at the next falling edge.
  task automatic step(logic e, logic [15:0] len, logic b, logic mc, logic f,
                      logic [1:0] m, logic g, logic p, logic c);
    string qtag;
    eof_i = e; frame_len_i = len; is_bcast_i = b; is_mcast_i = mc;
    is_flood_i = f; lim_mode_i = m; add_gap_i = g; add_pre_i = p; acc_clr_i = c;
    @(posedge clk);
    e_acc    = c ? 32'd0 : (e_qual ? sat_add(e_acc, e_chg) : e_acc);
    last_clr = c;
    e_qual   = e & qualifies(m, b, mc, f);
    e_chg    = e_qual ? cost(len, g, p) : 17'd0;
    @(negedge clk);
    if (!e)          qtag = "R9";
    else if (!e_qual) qtag = "R8";
    else             qtag = mode_tag(m);
    check(qtag, 32'(qual_o), 32'(e_qual));
    check(e_qual ? "R7" : qtag, 32'(charge_o), 32'(e_chg));
    check(last_clr ? "R11" : "R10", acc_o, e_acc);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; eof_i = 0; frame_len_i = 0; is_bcast_i = 0; is_mcast_i = 0;
    is_flood_i = 0; lim_mode_i = 0; add_gap_i = 0; add_pre_i = 0; acc_clr_i = 0;
    e_qual = 0; e_chg = 0; e_acc = 0; last_clr = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", 32'(qual_o), 0);
    check("R1", 32'(charge_o), 0);
    check("R1", acc_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Every mode against every flag combination, with every overhead pair.
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 8; k++)
        for (int o = 0; o < 4; o++)
          step(1, 16'd64 + 16'(k), k[2], k[1], k[0], 2'(m), o[1], o[0], 0);

    // R6: broadcast plus multicast in mode 3 still qualifies with charge 100+12+8
    step(1, 16'd100, 1, 1, 0, 2'd3, 1, 1, 0);
    check("R6", 32'(qual_o), 1);
    check("R6", 32'(charge_o), 32'd120);

    // R11: clear on the same edge as a pending charge
    step(1, 16'd500, 0, 0, 0, 2'd0, 0, 0, 0);
    step(0, 16'd0, 0, 0, 0, 2'd0, 0, 0, 1);
    check("R11", acc_o, 0);
    step(0, 16'd0, 0, 0, 0, 2'd0, 0, 0, 0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], 16'($urandom), r[1], r[2], r[3], r[5:4], r[6], r[7],
           (r[12:8] == 5'd0));
    end

    // R10: saturation with maximum-length frames
    step(0, 16'd0, 0, 0, 0, 2'd0, 0, 0, 1);
    for (int i = 0; i < 65540; i++)
      step(1, 16'hFFFF, 0, 0, 0, 2'd0, 1, 1, 0);
    step(0, 16'd0, 0, 0, 0, 2'd0, 0, 0, 0);
    check("R10", acc_o, 32'hFFFF_FFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule